// File: doc/BRIEF.md
# Dual program counter sequencer

This block holds the two program counters of an instruction stream that has been split into an execute-side stream and a flow-side stream. Both counters start from one shared entry address. The execute counter walks toward higher addresses and the flow counter walks toward lower addresses. On every issue cycle, one full bundle issues, made of one half-bundle from each side. Each counter then moves by the byte length of the half-bundle its own side has just consumed.

A stream with no work for some cycles stores no half-bundle in memory for them. Instead, the half-bundle of the *other* stream carries a 3-bit skip count in its alignment-hole bits. The stream named by that count then shows a no-op for that many issue cycles, and its counter holds. When the hole cannot encode the gap, software stores an explicit no-op half-bundle, and the block treats it as an ordinary half-bundle.

A taken branch loads both counters with the target. Targets are always entry points of extended basic blocks. A stall freezes everything.

Each side is one lane with two states. In `LN_FETCH` the lane consumes a half-bundle and advances its counter. In `LN_SKIP` the lane outputs a no-op and counts its skip value down. The lane transitions are:
- **skip-load**: `LN_FETCH` to `LN_SKIP`, when the other side's hole holds a non-zero count.
- **count-down**: `LN_SKIP` to `LN_SKIP`, while the count is above one.
- **expire**: `LN_SKIP` to `LN_FETCH`, when the count is one.
- **redirect**: any state to `LN_FETCH`, on a taken branch.
- **hold**: the lane keeps its state, on a stall.

Top module: `dual_pc_sequencer`

## Requirements
- R1: During and right after reset, `xpc` and `fpc` both equal the parameter `RESET_ENTRY` (default 0x1000), `x_fetch` and `f_fetch` are 1, and `x_nop` and `f_nop` are 0.
- R2: On an issue cycle (`stall`=0, `br_valid`=0) with `x_fetch`=1, `xpc` becomes `xpc + x_len` at the next rising edge, modulo 2^AW.
- R3: On an issue cycle with `f_fetch`=1, `fpc` becomes `fpc - f_len` at the next rising edge, modulo 2^AW.
- R4: On a cycle with `stall`=0 and `br_valid`=1, both counters load `br_entry` at the next edge. Both lanes return to fetching, which cancels any pending skip, and the hole inputs of that cycle have no effect.
- R5: If an issue cycle has `x_fetch`=1 and `x_hole`=N (N from 1 to 7; 0 means no skip) while the flow lane fetches, then the flow lane shows `f_fetch`=0 and `f_nop`=1 for the next N issue cycles, with `fpc` unchanged. After that it fetches again.
- R6: Symmetrically, an issue cycle with `f_fetch`=1 and `f_hole`=N (1 to 7) while the execute lane fetches makes the execute lane skip the next N issue cycles, with `xpc` unchanged.
- R7: A hole field is ignored when its own lane is skipping, and also when the lane it targets is already skipping. The remaining count of that lane is not reloaded.
- R8: While `stall`=1, both counters, both fetch/no-op outputs and both pending skip counts hold, whatever the other inputs are (including `br_valid`).
- R9: Both lanes can enter a skip on the same issue cycle, each with its own count. A hole value of 0 (an explicit no-op half-bundle) advances like any other half-bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze all state this cycle |
| br_valid | input | 1 | Taken transfer of control |
| br_entry | input | AW | Entry-point address of the branch target |
| x_len | input | LW | Byte length of the current execute half-bundle |
| x_hole | input | SKW | Skip count for the flow lane, from execute hole bits |
| f_len | input | LW | Byte length of the current flow half-bundle |
| f_hole | input | SKW | Skip count for the execute lane, from flow hole bits |
| xpc | output | AW | Execute-side program counter |
| fpc | output | AW | Flow-side program counter |
| x_fetch | output | 1 | Execute lane consumes a half-bundle this cycle |
| x_nop | output | 1 | Execute lane issues an elided no-op |
| f_fetch | output | 1 | Flow lane consumes a half-bundle this cycle |
| f_nop | output | 1 | Flow lane issues an elided no-op |

## Verification
Every result of this block is registered. Counter moves, skip entry and exit, and branch loads all appear on the first rising edge after the cycle that carries the stimulus, and a stalled cycle moves that edge forward by one. The driver applies one cycle of inputs after each falling edge and pushes the expected post-edge state into a queue. The monitor pops that entry 2 ns after the next rising edge, so each comparison sees exactly one edge of effect. Skip windows are checked cycle by cycle: every issue cycle of the window has its own expected entry, with the no-op flag set and the counter held.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    typedef enum logic {
        LN_FETCH = 1'b0,
        LN_SKIP  = 1'b1
    } lane_state_e;
endpackage

// File: rtl/dsq_lane.sv
module dsq_lane
    import dsq_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned LW = 6,
    parameter int unsigned SKW = 3,
    parameter bit GO_UP = 1'b1,
    parameter logic [AW-1:0] RESET_ENTRY = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          br_take,
    input  logic [AW-1:0] br_entry,
    input  logic [LW-1:0] hb_len,
    input  logic          skip_load,
    input  logic [SKW-1:0] skip_num,
    output logic [AW-1:0] pc_o,
    output logic          fetch_o,
    output logic          nop_o
);
    localparam logic [SKW-1:0] CNT_ONE = SKW'(1);

    lane_state_e    state_q, state_d;
    logic [SKW-1:0] cnt_q, cnt_d;
    logic [AW-1:0]  pc_q, pc_d, pc_step;
    logic [AW-1:0]  len_ext;

    assign len_ext = AW'(hb_len);

    generate
        if (GO_UP) begin : g_up
            assign pc_step = pc_q + len_ext;
        end else begin : g_down
            assign pc_step = pc_q - len_ext;
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_FETCH;
            cnt_q   <= '0;
            pc_q    <= RESET_ENTRY;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pc_q    <= pc_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pc_d    = pc_q;
        if (issue) begin
            if (br_take) begin
                state_d = LN_FETCH;
                cnt_d   = '0;
                pc_d    = br_entry;
            end else begin
                unique case (state_q)
                    LN_FETCH: begin
                        pc_d = pc_step;
                        if (skip_load && (skip_num != '0)) begin
                            state_d = LN_SKIP;
                            cnt_d   = skip_num;
                        end
                    end
                    LN_SKIP: begin
                        if (cnt_q == CNT_ONE) begin
                            state_d = LN_FETCH;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - CNT_ONE;
                        end
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        pc_o    = pc_q;
        fetch_o = (state_q == LN_FETCH);
        nop_o   = (state_q == LN_SKIP);
    end
endmodule

// File: rtl/dual_pc_sequencer.sv
module dual_pc_sequencer #(
    parameter int unsigned AW = 32,
    parameter int unsigned LW = 6,
    parameter int unsigned SKW = 3,
    parameter logic [AW-1:0] RESET_ENTRY = 32'h0000_1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stall,
    input  logic           br_valid,
    input  logic [AW-1:0]  br_entry,
    input  logic [LW-1:0]  x_len,
    input  logic [SKW-1:0] x_hole,
    input  logic [LW-1:0]  f_len,
    input  logic [SKW-1:0] f_hole,
    output logic [AW-1:0]  xpc,
    output logic [AW-1:0]  fpc,
    output logic           x_fetch,
    output logic           x_nop,
    output logic           f_fetch,
    output logic           f_nop
);
    logic issue;
    assign issue = !stall;

    // execute lane: forward, skip count carried by the flow hole
    dsq_lane #(
        .AW(AW), .LW(LW), .SKW(SKW), .GO_UP(1'b1), .RESET_ENTRY(RESET_ENTRY)
    ) u_xlane (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .br_take  (br_valid),
        .br_entry (br_entry),
        .hb_len   (x_len),
        .skip_load(f_fetch),
        .skip_num (f_hole),
        .pc_o     (xpc),
        .fetch_o  (x_fetch),
        .nop_o    (x_nop)
    );

    // flow lane: backward, skip count carried by the execute hole
    dsq_lane #(
        .AW(AW), .LW(LW), .SKW(SKW), .GO_UP(1'b0), .RESET_ENTRY(RESET_ENTRY)
    ) u_flane (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .br_take  (br_valid),
        .br_entry (br_entry),
        .hb_len   (f_len),
        .skip_load(x_fetch),
        .skip_num (x_hole),
        .pc_o     (fpc),
        .fetch_o  (f_fetch),
        .nop_o    (f_nop)
    );
endmodule

// File: rtl/dual_pc_sequencer_chk.sv
module dual_pc_sequencer_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned LW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall,
    input logic          br_valid,
    input logic [AW-1:0] br_entry,
    input logic [LW-1:0] x_len,
    input logic [LW-1:0] f_len,
    input logic [AW-1:0] xpc,
    input logic [AW-1:0] fpc,
    input logic          x_fetch,
    input logic          f_fetch
);
    // R2
    xpc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !br_valid && x_fetch) |=> (xpc == $past(xpc) + AW'($past(x_len))));

    // R3
    fpc_retreat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !br_valid && f_fetch) |=> (fpc == $past(fpc) - AW'($past(f_len))));

    // R4
    branch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && br_valid) |=> (xpc == $past(br_entry) && fpc == $past(br_entry)
                                  && x_fetch && f_fetch));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(xpc) && $stable(fpc) && $stable(x_fetch) && $stable(f_fetch)));

    // R6
    xskip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !x_fetch) |=> (xpc == $past(xpc)));

    // R5
    fskip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !f_fetch) |=> (fpc == $past(fpc)));
endmodule

bind dual_pc_sequencer dual_pc_sequencer_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .br_valid(br_valid),
    .br_entry(br_entry), .x_len(x_len), .f_len(f_len),
    .xpc(xpc), .fpc(fpc), .x_fetch(x_fetch), .f_fetch(f_fetch)
);

// File: tb/tb_dual_pc_sequencer.sv
module tb_dual_pc_sequencer;
    localparam int unsigned AW = 32;
    localparam int unsigned LW = 6;
    localparam int unsigned SKW = 3;
    localparam logic [AW-1:0] ENTRY0 = 32'h0000_1000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           stall = 1'b0;
    logic           br_valid = 1'b0;
    logic [AW-1:0]  br_entry = '0;
    logic [LW-1:0]  x_len = '0;
    logic [SKW-1:0] x_hole = '0;
    logic [LW-1:0]  f_len = '0;
    logic [SKW-1:0] f_hole = '0;
    logic [AW-1:0]  xpc, fpc;
    logic           x_fetch, x_nop, f_fetch, f_nop;

    always #4 clk = ~clk;

    dual_pc_sequencer #(.AW(AW), .LW(LW), .SKW(SKW), .RESET_ENTRY(ENTRY0)) dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .br_valid(br_valid),
        .br_entry(br_entry), .x_len(x_len), .x_hole(x_hole),
        .f_len(f_len), .f_hole(f_hole), .xpc(xpc), .fpc(fpc),
        .x_fetch(x_fetch), .x_nop(x_nop), .f_fetch(f_fetch), .f_nop(f_nop)
    );

    typedef struct {
        logic [AW-1:0] xpc;
        logic [AW-1:0] fpc;
        logic          xf;
        logic          ff;
        string         tag;
    } exp_t;

    exp_t sbq[$];
    int total = 0;
    int bad = 0;

    // bench model, built from the requirements
    logic [AW-1:0]  m_xpc = ENTRY0;
    logic [AW-1:0]  m_fpc = ENTRY0;
    logic [SKW-1:0] m_xs = '0;
    logic [SKW-1:0] m_fs = '0;

    task automatic check(input string tag, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic step(input logic st, input logic br, input logic [AW-1:0] tgt,
                        input logic [LW-1:0] xl, input logic [SKW-1:0] xh,
                        input logic [LW-1:0] fl, input logic [SKW-1:0] fh,
                        input string tag);
        logic xf_old, ff_old;
        logic [SKW-1:0] nxs, nfs;
        exp_t e;
        @(negedge clk);
        stall = st; br_valid = br; br_entry = tgt;
        x_len = xl; x_hole = xh; f_len = fl; f_hole = fh;
        xf_old = (m_xs == '0);
        ff_old = (m_fs == '0);
        if (!st) begin
            if (br) begin
                m_xpc = tgt; m_fpc = tgt; m_xs = '0; m_fs = '0;
            end else begin
                nxs = (m_xs != '0) ? m_xs - 1'b1 : ((ff_old && fh != '0) ? fh : '0);
                nfs = (m_fs != '0) ? m_fs - 1'b1 : ((xf_old && xh != '0) ? xh : '0);
                if (xf_old) m_xpc = m_xpc + AW'(xl);
                if (ff_old) m_fpc = m_fpc - AW'(fl);
                m_xs = nxs; m_fs = nfs;
            end
        end
        e.xpc = m_xpc; e.fpc = m_fpc;
        e.xf = (m_xs == '0); e.ff = (m_fs == '0);
        e.tag = tag;
        sbq.push_back(e);
    endtask

    // monitor: one edge of effect per queued item
    exp_t got;
    always @(posedge clk) begin
        #2;
        if (sbq.size() > 0) begin
            got = sbq.pop_front();
            check(got.tag, "xpc", xpc, got.xpc);
            check(got.tag, "fpc", fpc, got.fpc);
            check(got.tag, "x_fetch", AW'(x_fetch), AW'(got.xf));
            check(got.tag, "f_fetch", AW'(f_fetch), AW'(got.ff));
            check(got.tag, "x_nop", AW'(x_nop), AW'(!got.xf));
            check(got.tag, "f_nop", AW'(f_nop), AW'(!got.ff));
        end
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "xpc", xpc, ENTRY0);
        check("R1", "fpc", fpc, ENTRY0);
        check("R1", "fetch", AW'({x_fetch, f_fetch, x_nop, f_nop}), AW'(4'b1100));
        rst_n = 1'b1;

        // R2 R3 plain advance with several lengths
        step(0, 0, '0, 6'd5,  3'd0, 6'd3,  3'd0, "R2_R3");
        step(0, 0, '0, 6'd63, 3'd0, 6'd17, 3'd0, "R2_R3");
        step(0, 0, '0, 6'd0,  3'd0, 6'd1,  3'd0, "R2_R3");
        // R5 execute hole skips the flow lane 3 cycles; R7 flow hole ignored while skipping
        step(0, 0, '0, 6'd8, 3'd3, 6'd4, 3'd0, "R5");
        step(0, 0, '0, 6'd2, 3'd0, 6'd9, 3'd5, "R7");
        step(0, 0, '0, 6'd2, 3'd6, 6'd9, 3'd0, "R7");
        step(0, 0, '0, 6'd2, 3'd0, 6'd9, 3'd0, "R5");
        step(0, 0, '0, 6'd2, 3'd0, 6'd6, 3'd0, "R5");
        // R6 flow hole skips the execute lane 2 cycles
        step(0, 0, '0, 6'd4, 3'd0, 6'd4, 3'd2, "R6");
        step(0, 0, '0, 6'd7, 3'd4, 6'd5, 3'd0, "R6");
        step(0, 0, '0, 6'd7, 3'd0, 6'd5, 3'd0, "R6");
        // flow skip from the cycle above (hole 4 while exe skipped -> ignored, R7)
        step(0, 0, '0, 6'd3, 3'd0, 6'd2, 3'd0, "R7");
        // R8 stall with branch and holes present
        step(0, 0, '0, 6'd1, 3'd4, 6'd1, 3'd0, "R5");
        step(1, 1, 32'hDEAD_0000, 6'd9, 3'd7, 6'd9, 3'd7, "R8");
        step(1, 0, '0, 6'd9, 3'd0, 6'd9, 3'd0, "R8");
        step(0, 0, '0, 6'd2, 3'd0, 6'd2, 3'd0, "R8");
        // R4 branch during active skip, holes ignored
        step(0, 1, 32'h0000_2000, 6'd9, 3'd7, 6'd9, 3'd7, "R4");
        step(0, 0, '0, 6'd4, 3'd0, 6'd4, 3'd0, "R4");
        // R9 both lanes skip at once with own counts, then explicit no-op halves
        step(0, 0, '0, 6'd6, 3'd1, 6'd6, 3'd2, "R9");
        step(0, 0, '0, 6'd6, 3'd0, 6'd6, 3'd0, "R9");
        step(0, 0, '0, 6'd6, 3'd0, 6'd6, 3'd0, "R9");
        step(0, 0, '0, 6'd1, 3'd0, 6'd1, 3'd0, "R9");
        // R3 wrap below zero
        step(0, 1, 32'h0000_0004, 6'd0, 3'd0, 6'd0, 3'd0, "R4");
        step(0, 0, '0, 6'd2, 3'd0, 6'd8, 3'd0, "R3");
        step(0, 0, '0, 6'd2, 3'd0, 6'd8, 3'd0, "R3");
        step(1, 0, '0, 6'd0, 3'd0, 6'd0, 3'd0, "R8");
        repeat (3) @(posedge clk);
        #3;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule